// File: doc/BRIEF.md
# Sum-of-Products Output Macrocell Bank

This block is the output stage of a small programmable logic device. It takes eight cells' worth of product-term results from an external AND array. Each cell ORs its terms, applies a polarity choice and, depending on the configuration, either drives the pad straight from that sum or from a D flip-flop. Each cell then drives its pad data and tristate enable. It also returns a feedback signal to the array.

Two global configuration bits pick one of three operating modes for all cells at once. Each cell also has its own polarity bit and direction bit. The mode decides several things:

- which product term, if any, controls the tristate enable;
- whether feedback comes from the cell's own pad, from a neighbouring pad, or from the register;
- whether the two dual-purpose pins act as array inputs or take on their clock and enable roles.

Cell `i` sits on the pin numbered 12+i: cell 0 is the lower edge cell and cell 7 is the upper edge cell. Cells 3 and 4 are the innermost cells. The registers load synchronously from a test preload path and clear on reset.

Top module: `sop_macrocell_bank`

## Requirements
- R1: The mode is decoded from `{cfg_a,cfg_b}` as follows: `10` selects simple, `11` selects complex, `01` selects registered, and `00` also selects simple.
- R2: While `pad_oe[i]` is 1, `pad_out[i]` equals the cell's source value when `cell_pol[i]`=1 (active high) and its inverse when `cell_pol[i]`=0 (active low). While `pad_oe[i]` is 0, `pad_out[i]` is 0.
- R3: In simple mode, a non-inner cell with `cell_dir[i]`=0 is always enabled, and its source is the OR of all eight terms. With `cell_dir[i]`=1 it is an input and `pad_oe[i]`=0.
- R4: In simple mode, the inner cells 3 and 4 are always enabled outputs driven by the OR of all eight terms, whatever their `cell_dir` bit. The pad values of these two cells never appear on any feedback line.
- R5: In simple mode, the feedback lines are routed as follows: `fb[0]`=`pin11_in`, `fb[7]`=`pin1_in`, `fb[i]`=`pad_in[i-1]` for i=1..3, and `fb[i]`=`pad_in[i+1]` for i=4..6.
- R6: In complex mode, term 0 of each cell (bit `8i` of `pterm`) is its output enable, and its source is the OR of terms 1 to 7.
- R7: In complex mode, `fb[0]` carries `pin11_in`, `fb[7]` carries `pin1_in`, and cells 1 to 6 feed back their own pad.
- R8: In registered mode, a cell with `cell_dir[i]`=0 captures the OR of its eight terms on each rising `clk` edge. Its source is the register, it is enabled exactly when `pin11_in` is 0, and `fb[i]` is the inverted register output.
- R9: In registered mode, a cell with `cell_dir[i]`=1 is combinational. Term 0 enables it, its source is the OR of terms 1 to 7, and `fb[i]` is its own pad.
- R10: `arr_pin1` and `arr_pin11` follow `pin1_in` and `pin11_in` in simple and complex modes. Both are 0 in registered mode.
- R11: `rst`=1 at a rising edge clears every register to 0.
- R12: `pre_en`=1 at a rising edge loads `pre_data` into all registers, whatever the mode. This takes precedence over capture, and reset takes precedence over it.
- R13: Outside registered mode, and for cells with `cell_dir[i]`=1, the registers keep their contents when no preload occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock (the clock pin in registered mode) |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_a | input | 1 | Global mode bit A |
| cfg_b | input | 1 | Global mode bit B |
| cell_pol | input | NCELL | Per-cell polarity, 1 = active high |
| cell_dir | input | NCELL | Per-cell direction/configuration bit |
| pterm | input | NCELL*NTERM | Product terms, cell i at bits [NTERM*i +: NTERM] |
| pin1_in | input | 1 | Dual-purpose pin 1 value |
| pin11_in | input | 1 | Dual-purpose pin 11 value (active-low enable in registered mode) |
| pad_in | input | NCELL | Values present on the cell pads |
| pre_en | input | 1 | Register preload strobe |
| pre_data | input | NCELL | Register preload values |
| pad_out | output | NCELL | Pad drive data |
| pad_oe | output | NCELL | Pad tristate enable, 1 = drive |
| fb | output | NCELL | Feedback to the AND array |
| arr_pin1 | output | 1 | Array input from pin 1 |
| arr_pin11 | output | 1 | Array input from pin 11 |

## Verification
Some relations are checked on every cycle:

- In registered mode, the enable of a register cell tracks pin 11.
- The register feedback agrees with the polarity-corrected pad.
- Each register holds the previous cycle's term sum or preload value.
- The inner cells stay enabled in simple mode.
- The complex-mode edge lines carry the dual-purpose pins.
- The dual-purpose array inputs are blocked in registered mode.

The bench's scenarios are needed to show the rest:

- the full neighbour routing of simple mode;
- reset clearing to zero;
- preload across modes;
- register contents held through a detour into another mode.

The bench shows these by comparing every output against a behavioural model on every cycle.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    MODE_SIMPLE     = 2'd0,
    MODE_COMPLEX    = 2'd1,
    MODE_REGISTERED = 2'd2
  } cell_mode_e;
endpackage

// File: rtl/smb_mode_dec.sv
module smb_mode_dec
  import smb_pkg::*;
(
  input  logic       cfg_a,
  input  logic       cfg_b,
  output cell_mode_e mode
);
  always_comb begin
    case ({cfg_a, cfg_b})
      2'b11:   mode = MODE_COMPLEX;
      2'b01:   mode = MODE_REGISTERED;
      default: mode = MODE_SIMPLE;   // 10 and the unused 00
    endcase
  end
endmodule

// File: rtl/smb_cell.sv
module smb_cell
  import smb_pkg::*;
#(
  parameter int NTERM = 8,
  parameter bit INNER = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  cell_mode_e       mode,
  input  logic             pol,
  input  logic             dir,
  input  logic [NTERM-1:0] terms,
  input  logic             oe_pin_n,
  input  logic             pre_en,
  input  logic             pre_d,
  output logic             pad_o,
  output logic             pad_oe,
  output logic             q_n
);
  logic q;
  logic sum_all;
  logic sum_rest;
  logic src;
  logic drv;

  assign sum_all  = |terms;
  assign sum_rest = |terms[NTERM-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (pre_en) begin
      q <= pre_d;
    end else if (mode == MODE_REGISTERED && !dir) begin
      q <= sum_all;
    end
  end

  always_comb begin
    src = 1'b0;
    drv = 1'b0;
    case (mode)
      MODE_COMPLEX: begin
        drv = terms[0];
        src = sum_rest;
      end
      MODE_REGISTERED: begin
        if (!dir) begin
          drv = !oe_pin_n;
          src = q;
        end else begin
          drv = terms[0];
          src = sum_rest;
        end
      end
      default: begin
        if (dir && !INNER) begin
          drv = 1'b0;
          src = 1'b0;
        end else begin
          drv = 1'b1;
          src = sum_all;
        end
      end
    endcase
  end

  assign pad_oe = drv;
  assign pad_o  = drv & (pol ? src : !src);
  assign q_n    = !q;
endmodule

// File: rtl/smb_fb_route.sv
module smb_fb_route
  import smb_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  cell_mode_e       mode,
  input  logic [NCELL-1:0] dir,
  input  logic [NCELL-1:0] q_n,
  input  logic [NCELL-1:0] pad_in,
  input  logic             pin1,
  input  logic             pin11,
  output logic [NCELL-1:0] fb,
  output logic             arr1,
  output logic             arr11
);
  localparam int HALF = NCELL / 2;

  for (genvar i = 0; i < NCELL; i++) begin : g_fb
    logic simple_src;
    logic cplx_src;
    if (i == 0) begin : g_low_edge
      assign simple_src = pin11;
      assign cplx_src   = pin11;
    end else if (i == NCELL - 1) begin : g_high_edge
      assign simple_src = pin1;
      assign cplx_src   = pin1;
    end else if (i < HALF) begin : g_lower
      assign simple_src = pad_in[i-1];
      assign cplx_src   = pad_in[i];
    end else begin : g_upper
      assign simple_src = pad_in[i+1];
      assign cplx_src   = pad_in[i];
    end

    always_comb begin
      case (mode)
        MODE_COMPLEX:    fb[i] = cplx_src;
        MODE_REGISTERED: fb[i] = dir[i] ? pad_in[i] : q_n[i];
        default:         fb[i] = simple_src;
      endcase
    end
  end

  assign arr1  = (mode != MODE_REGISTERED) & pin1;
  assign arr11 = (mode != MODE_REGISTERED) & pin11;
endmodule

// File: rtl/sop_macrocell_bank.sv
module sop_macrocell_bank
  import smb_pkg::*;
#(
  parameter int NCELL = 8,
  parameter int NTERM = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_a,
  input  logic                   cfg_b,
  input  logic [NCELL-1:0]       cell_pol,
  input  logic [NCELL-1:0]       cell_dir,
  input  logic [NCELL*NTERM-1:0] pterm,
  input  logic                   pin1_in,
  input  logic                   pin11_in,
  input  logic [NCELL-1:0]       pad_in,
  input  logic                   pre_en,
  input  logic [NCELL-1:0]       pre_data,
  output logic [NCELL-1:0]       pad_out,
  output logic [NCELL-1:0]       pad_oe,
  output logic [NCELL-1:0]       fb,
  output logic                   arr_pin1,
  output logic                   arr_pin11
);
  localparam int HALF = NCELL / 2;

  cell_mode_e       mode;
  logic [NCELL-1:0] q_n;

  smb_mode_dec u_dec (
    .cfg_a (cfg_a),
    .cfg_b (cfg_b),
    .mode  (mode)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    smb_cell #(
      .NTERM (NTERM),
      .INNER ((i == HALF - 1) || (i == HALF))
    ) u_cell (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode),
      .pol      (cell_pol[i]),
      .dir      (cell_dir[i]),
      .terms    (pterm[i*NTERM +: NTERM]),
      .oe_pin_n (pin11_in),
      .pre_en   (pre_en),
      .pre_d    (pre_data[i]),
      .pad_o    (pad_out[i]),
      .pad_oe   (pad_oe[i]),
      .q_n      (q_n[i])
    );
  end

  smb_fb_route #(.NCELL(NCELL)) u_route (
    .mode   (mode),
    .dir    (cell_dir),
    .q_n    (q_n),
    .pad_in (pad_in),
    .pin1   (pin1_in),
    .pin11  (pin11_in),
    .fb     (fb),
    .arr1   (arr_pin1),
    .arr11  (arr_pin11)
  );
endmodule

// File: rtl/sop_macrocell_bank_chk.sv
module sop_macrocell_bank_chk #(
  parameter int NCELL = 8,
  parameter int NTERM = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_a,
  input logic                   cfg_b,
  input logic [NCELL-1:0]       cell_pol,
  input logic [NCELL-1:0]       cell_dir,
  input logic [NCELL*NTERM-1:0] pterm,
  input logic                   pin1_in,
  input logic                   pin11_in,
  input logic                   pre_en,
  input logic [NCELL-1:0]       pre_data,
  input logic [NCELL-1:0]       pad_out,
  input logic [NCELL-1:0]       pad_oe,
  input logic [NCELL-1:0]       fb,
  input logic                   arr_pin1,
  input logic                   arr_pin11
);
  localparam int HALF = NCELL / 2;

  logic is_reg, is_cplx, is_simple;
  assign is_reg    = !cfg_a && cfg_b;
  assign is_cplx   = cfg_a && cfg_b;
  assign is_simple = !cfg_b;

  for (genvar i = 0; i < NCELL; i++) begin : g_chk
    p_reg_oe_r8: assert property (@(posedge clk) disable iff (rst)
      (is_reg && !cell_dir[i]) |-> (pad_oe[i] == !pin11_in));

    p_reg_fb_pol_r2: assert property (@(posedge clk) disable iff (rst)
      (is_reg && !cell_dir[i] && pad_oe[i]) |->
        (fb[i] == !(cell_pol[i] ? pad_out[i] : !pad_out[i])));

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
      (is_reg && !cell_dir[i] && !pre_en) |=>
        (!(is_reg && !cell_dir[i]) || (fb[i] == !$past(|pterm[i*NTERM +: NTERM]))));

    p_preload_r12: assert property (@(posedge clk) disable iff (rst)
      pre_en |=> (!(is_reg && !cell_dir[i]) || (fb[i] == !$past(pre_data[i]))));

    if (i == HALF - 1 || i == HALF) begin : g_inner
      p_inner_on_r4: assert property (@(posedge clk) disable iff (rst)
        is_simple |-> pad_oe[i]);
    end
  end

  p_cplx_edges_r7: assert property (@(posedge clk) disable iff (rst)
    is_cplx |-> (fb[0] == pin11_in && fb[NCELL-1] == pin1_in));

  p_arr_block_r10: assert property (@(posedge clk) disable iff (rst)
    is_reg |-> (!arr_pin1 && !arr_pin11));
endmodule

bind sop_macrocell_bank sop_macrocell_bank_chk #(.NCELL(NCELL), .NTERM(NTERM)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_a     (cfg_a),
  .cfg_b     (cfg_b),
  .cell_pol  (cell_pol),
  .cell_dir  (cell_dir),
  .pterm     (pterm),
  .pin1_in   (pin1_in),
  .pin11_in  (pin11_in),
  .pre_en    (pre_en),
  .pre_data  (pre_data),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .fb        (fb),
  .arr_pin1  (arr_pin1),
  .arr_pin11 (arr_pin11)
);

// File: tb/sop_macrocell_bank_tb_top.sv
module sop_macrocell_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_a, cfg_b;
  logic [7:0]  cell_pol, cell_dir;
  logic [63:0] pterm;
  logic        pin1_in, pin11_in;
  logic [7:0]  pad_in;
  logic        pre_en;
  logic [7:0]  pre_data;
  logic [7:0]  pad_out, pad_oe, fb;
  logic        arr_pin1, arr_pin11;

  int   checks = 0;
  int   fails  = 0;
  logic [7:0] m_q;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  sop_macrocell_bank #(.NCELL(8), .NTERM(8)) dut_i (
    .clk(clk), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .cell_pol(cell_pol), .cell_dir(cell_dir), .pterm(pterm),
    .pin1_in(pin1_in), .pin11_in(pin11_in), .pad_in(pad_in),
    .pre_en(pre_en), .pre_data(pre_data),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb),
    .arr_pin1(arr_pin1), .arr_pin11(arr_pin11)
  );

  // R1: 0 simple, 1 complex, 2 registered
  function automatic int mode_of();
    if (cfg_a && cfg_b) return 1;
    if (!cfg_a && cfg_b) return 2;
    return 0;
  endfunction

  function automatic string tag_of(int md, int i, bit is_fb);
    if (md == 0) return is_fb ? "R5" : ((i == 3 || i == 4) ? "R4" : "R3");
    if (md == 1) return is_fb ? "R7" : "R6";
    return cell_dir[i] ? "R9" : "R8";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic compare();
    int md = mode_of();
    for (int i = 0; i < 8; i++) begin
      logic s8, s7, en, val, e_out, e_fb;
      s8 = |pterm[i*8 +: 8];
      s7 = |pterm[i*8+1 +: 7];
      if (md == 0) begin
        if (cell_dir[i] && !(i == 3 || i == 4)) begin en = 0; val = 0; end
        else begin en = 1; val = s8; end
        if (i == 0) e_fb = pin11_in;
        else if (i == 7) e_fb = pin1_in;
        else if (i < 4) e_fb = pad_in[i-1];
        else e_fb = pad_in[i+1];
      end else if (md == 1) begin
        en = pterm[i*8]; val = s7;
        e_fb = (i == 0) ? pin11_in : (i == 7) ? pin1_in : pad_in[i];
      end else if (!cell_dir[i]) begin
        en = !pin11_in; val = m_q[i]; e_fb = !m_q[i];
      end else begin
        en = pterm[i*8]; val = s7; e_fb = pad_in[i];
      end
      e_out = en ? (cell_pol[i] ? val : !val) : 1'b0;
      chk({tag_of(md, i, 0), "/R2"}, $sformatf("R1 mode=%0d cell=%0d oe", md, i), 32'(pad_oe[i]), 32'(en));
      chk({tag_of(md, i, 0), "/R2"}, $sformatf("R1 mode=%0d cell=%0d out", md, i), 32'(pad_out[i]), 32'(e_out));
      chk(tag_of(md, i, 1), $sformatf("R1 mode=%0d cell=%0d fb", md, i), 32'(fb[i]), 32'(e_fb));
    end
    chk("R10", "arr_pin1", 32'(arr_pin1), 32'((md != 2) && pin1_in));
    chk("R10", "arr_pin11", 32'(arr_pin11), 32'((md != 2) && pin11_in));
  endtask

  // Registers updated for the edge just passed, then all outputs compared.
  task automatic step();
    @(negedge clk);
    if (rst) m_q = '0;
    else if (pre_en) m_q = pre_data;
    else if (mode_of() == 2) begin
      for (int i = 0; i < 8; i++)
        if (!cell_dir[i]) m_q[i] = |pterm[i*8 +: 8];
    end
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    m_q = '0;
    rst = 1; cfg_a = 0; cfg_b = 1; cell_pol = 8'hFF; cell_dir = 8'h00;
    pterm = '1; pin1_in = 0; pin11_in = 0; pad_in = 8'h00;
    pre_en = 0; pre_data = 8'h00;
    step(); step();
    // R11: registers cleared despite all terms high
    chk("R11", "fb after reset", 32'(fb), 32'hFF);
    chk("R11", "pad_out after reset", 32'(pad_out), 32'h00);
    rst = 0; pre_en = 1; pre_data = 8'hA5; pterm = '0;
    step();
    chk("R12", "fb after preload", 32'(fb), 32'h5A);
    chk("R12", "pad_out after preload", 32'(pad_out), 32'hA5);
    pre_en = 0; cfg_a = 1; cfg_b = 0; pterm = '1;
    step(); step(); step();
    // R13: back to registered, look before the next capture edge
    cfg_a = 0; cfg_b = 1;
    #2;
    chk("R13", "fb held across simple mode", 32'(fb), 32'h5A);
    chk("R13", "pad_out held across simple mode", 32'(pad_out), 32'hA5);
    // Directed R4: all cells asked to be inputs in simple mode
    cfg_a = 1; cfg_b = 0; cell_dir = 8'hFF; cell_pol = 8'h00; pterm = '0;
    step();
    chk("R4", "inner enables", 32'(pad_oe), 32'h18);
    chk("R4", "inner data active low", 32'(pad_out), 32'h18);
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 60; c++) begin
        cfg_a    = m[1];
        cfg_b    = m[0];
        pterm    = {$urandom, $urandom};
        pad_in   = 8'($urandom);
        cell_pol = 8'($urandom);
        cell_dir = 8'($urandom);
        pin1_in  = 1'($urandom);
        pin11_in = 1'($urandom);
        pre_en   = (($urandom % 8) == 0);
        pre_data = 8'($urandom);
        rst      = (($urandom % 40) == 0);
        step();
      end
    end
    rst = 0; pre_en = 0;
    step();
    done = 1'b1;
    report();
    $finish;
  end
endmodule